// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

The block sits between an instruction memory port and a decoder for an instruction set whose instructions are 1 to 12 bytes long and may start at any byte address. It requests aligned 4-byte words, holds them in a 16-byte queue, works out the length of the instruction at the head of the queue from its first bytes, and presents that instruction left-aligned on a 12-byte output. The output also carries a length field, a valid flag and the instruction's byte address. When the downstream stage accepts an instruction, the consumed bytes are removed by a byte-granular collapsing shift. The queue then refills from the memory port.

A redirect empties the queue in one cycle and restarts fetching at a new byte address. The word containing the target is fetched, and the bytes of that word that lie before the target are discarded. The memory port is a simple request/acknowledge pair. The returned word is taken in the same cycle that the acknowledge is high.

Top module: `fetch_aligner`

## Requirements
- R1: After reset the block presents no instruction, requests a word at fetch address 0 and reports head address 0.
- R2: A first byte of 0x00 to 0xBF gives a 2-byte instruction. A first byte of 0xF0 to 0xF7 gives a 1-byte instruction.
- R3: A first byte of 0xC0 to 0xEF starts an immediate form. Bits [1:0] of the second byte select an immediate of 1, 2, 4 or 8 bytes (00, 01, 10, 11), so the total length is 3, 4, 6 or 10 bytes.
- R4: A first byte of 0xF8 to 0xFB is a 1-byte prefix, and 0xFC to 0xFF is a prefix followed by one extension byte. In both cases an immediate-form body follows: its opcode byte, then a selector byte as in R3, then the immediate. The total length is 4 to 12 bytes.
- R5: The valid output is high exactly when the queue holds at least the decoded length of the head instruction and no redirect is applied.
- R6: While valid is high and ready is low, the valid flag, the length, the address and the instruction bytes stay unchanged in the next cycle.
- R7: The queue holds 16 bytes. A word is requested, if no redirect is applied, whenever at least 4 bytes are free after this cycle's consume. Each acknowledged word advances the fetch address by 4. Without an acknowledge, the request keeps its address.
- R8: In a redirect cycle, valid and the request are low. In the next cycle the queue is empty, the head address equals the target, the request goes to the target rounded down to a multiple of 4, and the first (target mod 4) bytes of that returned word are dropped.
- R9: The head address advances by the issued length on every accepted instruction.
- R10: With an always-acknowledging memory and ready held high, a stream of 1- and 2-byte instructions issues one instruction every clock once the first one appears.
- R11: Byte i of the instruction appears on bits [8i+7:8i] of the instruction output, so the first byte is on [7:0]. Output bytes at or beyond the length are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_o | output | 1 | Word request to instruction memory |
| fetch_addr_o | output | ADDR_W | Word-aligned fetch byte address |
| fetch_ack_i | input | 1 | Memory returns the requested word this cycle |
| fetch_data_i | input | 8*WORD_BYTES | Returned word, lowest address in bits [7:0] |
| redirect_i | input | 1 | Flush and restart at the target address |
| redirect_addr_i | input | ADDR_W | Redirect target byte address |
| insn_valid_o | output | 1 | Head instruction complete and presented |
| insn_ready_i | input | 1 | Downstream accepts the presented instruction |
| insn_len_o | output | 4 | Length of the head instruction in bytes |
| insn_addr_o | output | ADDR_W | Byte address of the head instruction |
| insn_bytes_o | output | 96 | Left-aligned instruction bytes, zero past the length |

## Verification
The first pattern is a dense run of 1- and 2-byte opcodes, including the range edges 0x00, 0xBF, 0xF0 and 0xF7, with ready held high. It separates a correct one-per-clock collapse from an aligner that loses a cycle on byte-offset heads. Immediate forms of every selector, and prefixed forms of 11 and 12 bytes, push the head across several fetch words. These patterns tell a wrong length table apart from a premature valid while only part of the instruction has arrived. Toggled ready and a memory that withholds acknowledges show whether a stalled head holds still and whether the request rule follows the free space. Redirects to targets with non-zero low address bits show whether the leading bytes of the first word are discarded and the head address restarts correctly.

// File: rtl/fa_pkg.sv
`timescale 1ns/1ps
package fa_pkg;
  localparam int unsigned INSN_MAX_BYTES = 12;
  localparam int unsigned LEN_W          = 4;

  localparam logic [7:0] OP_IMM_MIN  = 8'hC0;
  localparam logic [7:0] OP_ONE_MIN  = 8'hF0;
  localparam logic [7:0] OP_PFX1_MIN = 8'hF8;
  localparam logic [7:0] OP_PFX2_MIN = 8'hFC;

  function automatic logic [LEN_W-1:0] imm_bytes(input logic [1:0] sel);
    return LEN_W'(1) << sel;
  endfunction
endpackage

// File: rtl/fa_len_decode.sv
`timescale 1ns/1ps
module fa_len_decode
  import fa_pkg::*;
(
  input  logic [7:0]       op_i,
  input  logic [7:0]       b1_i,
  input  logic [7:0]       b2_i,
  input  logic [7:0]       b3_i,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    if (op_i >= OP_PFX2_MIN)      len_o = LEN_W'(4) + imm_bytes(b3_i[1:0]); // pfx+ext+op+sel
    else if (op_i >= OP_PFX1_MIN) len_o = LEN_W'(3) + imm_bytes(b2_i[1:0]); // pfx+op+sel
    else if (op_i >= OP_ONE_MIN)  len_o = LEN_W'(1);
    else if (op_i >= OP_IMM_MIN)  len_o = LEN_W'(2) + imm_bytes(b1_i[1:0]);
    else                          len_o = LEN_W'(2);
  end
endmodule

// File: rtl/fa_queue.sv
`timescale 1ns/1ps
module fa_queue #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned OUT_BYTES  = 12,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1),
  localparam int unsigned OFF_W     = $clog2(WORD_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic [CNT_W-1:0]        consume_i,
  input  logic                    push_i,
  input  logic [WORD_BYTES*8-1:0] push_data_i,
  input  logic [OFF_W-1:0]        push_skip_i,
  output logic [OUT_BYTES*8-1:0]  head_o,
  output logic [CNT_W-1:0]        count_o
);
  logic [DEPTH*8-1:0]      q_q, q_d, shifted;
  logic [WORD_BYTES*8-1:0] word_al;
  logic [CNT_W-1:0]        count_q, count_d, base, n_new;
  logic [CNT_W:0]          fill_end;

  always_comb begin
    shifted  = q_q >> {consume_i, 3'b000};
    word_al  = push_data_i >> {push_skip_i, 3'b000};
    base     = count_q - consume_i;
    n_new    = CNT_W'(WORD_BYTES) - CNT_W'(push_skip_i);
    fill_end = {1'b0, base} + {1'b0, n_new};
    q_d      = shifted;
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && ((CNT_W+1)'(i) >= {1'b0, base}) && ((CNT_W+1)'(i) < fill_end)) begin
        q_d[i*8 +: 8] = word_al[(i - int'(base))*8 +: 8];
      end
    end
    if (flush_i)     count_d = '0;
    else if (push_i) count_d = fill_end[CNT_W-1:0];
    else             count_d = base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= '0;
      count_q <= '0;
    end else begin
      q_q     <= q_d;
      count_q <= count_d;
    end
  end

  assign head_o  = q_q[OUT_BYTES*8-1:0];
  assign count_o = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH)); // R7
  AST_PUSH_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> fill_end <= (CNT_W+1)'(DEPTH)); // R7
  AST_FLUSH_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !push_i); // R8
endmodule

// File: rtl/fetch_aligner.sv
`timescale 1ns/1ps
module fetch_aligner
  import fa_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned QUEUE_BYTES = 16,
  parameter int unsigned WORD_BYTES  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  output logic                        fetch_req_o,
  output logic [ADDR_W-1:0]           fetch_addr_o,
  input  logic                        fetch_ack_i,
  input  logic [WORD_BYTES*8-1:0]     fetch_data_i,
  input  logic                        redirect_i,
  input  logic [ADDR_W-1:0]           redirect_addr_i,
  output logic                        insn_valid_o,
  input  logic                        insn_ready_i,
  output logic [LEN_W-1:0]            insn_len_o,
  output logic [ADDR_W-1:0]           insn_addr_o,
  output logic [INSN_MAX_BYTES*8-1:0] insn_bytes_o
);
  localparam int unsigned CNT_W = $clog2(QUEUE_BYTES + 1);
  localparam int unsigned OFF_W = $clog2(WORD_BYTES);

  logic [INSN_MAX_BYTES*8-1:0] head;
  logic [CNT_W-1:0]            count, consume;
  logic [CNT_W:0]              free_after;
  logic [LEN_W-1:0]            len;
  logic                        fire, push;
  logic [ADDR_W-1:0]           faddr_q, head_addr_q;
  logic [OFF_W-1:0]            skip_q;

  fa_len_decode i_dec (
    .op_i (head[7:0]),
    .b1_i (head[15:8]),
    .b2_i (head[23:16]),
    .b3_i (head[31:24]),
    .len_o(len)
  );

  assign insn_valid_o = !redirect_i && (count >= CNT_W'(len));
  assign fire         = insn_valid_o && insn_ready_i;
  assign consume      = fire ? CNT_W'(len) : '0;
  assign free_after   = (CNT_W+1)'(QUEUE_BYTES) - {1'b0, count} + {1'b0, consume};
  assign fetch_req_o  = !redirect_i && (free_after >= (CNT_W+1)'(WORD_BYTES));
  assign push         = fetch_req_o && fetch_ack_i;

  fa_queue #(
    .DEPTH     (QUEUE_BYTES),
    .WORD_BYTES(WORD_BYTES),
    .OUT_BYTES (INSN_MAX_BYTES)
  ) i_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (redirect_i),
    .consume_i  (consume),
    .push_i     (push),
    .push_data_i(fetch_data_i),
    .push_skip_i(skip_q),
    .head_o     (head),
    .count_o    (count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      faddr_q     <= '0;
      skip_q      <= '0;
      head_addr_q <= '0;
    end else if (redirect_i) begin
      faddr_q     <= {redirect_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      skip_q      <= redirect_addr_i[OFF_W-1:0];
      head_addr_q <= redirect_addr_i;
    end else begin
      if (push) begin
        faddr_q <= faddr_q + ADDR_W'(WORD_BYTES);
        skip_q  <= '0;
      end
      if (fire) head_addr_q <= head_addr_q + ADDR_W'(len);
    end
  end

  // zero bytes past the length so a stalled head is fully stable
  for (genvar g = 0; g < INSN_MAX_BYTES; g++) begin : g_mask
    assign insn_bytes_o[g*8 +: 8] = (LEN_W'(g) < len) ? head[g*8 +: 8] : 8'h00;
  end

  assign fetch_addr_o = faddr_q;
  assign insn_len_o   = len;
  assign insn_addr_o  = head_addr_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_o && !insn_ready_i |=> redirect_i || (insn_valid_o && $stable(insn_bytes_o)
      && $stable(insn_len_o) && $stable(insn_addr_o))); // R6
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_o && insn_ready_i |=> insn_addr_o == $past(insn_addr_o) + ADDR_W'($past(insn_len_o))); // R9
  AST_REDIRECT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> insn_addr_o == $past(redirect_addr_i) && !insn_valid_o); // R8
  AST_FETCH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && fetch_ack_i && !redirect_i |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(WORD_BYTES)); // R7
endmodule

// File: tb/test_fetch_aligner.sv
`timescale 1ns/1ps
module test_fetch_aligner;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        fetch_req_o, fetch_ack_i = 1'b1;
  logic [31:0] fetch_addr_o, redirect_addr_i = '0, insn_addr_o;
  logic [31:0] fetch_data_i;
  logic        redirect_i = 1'b0, insn_valid_o, insn_ready_i = 1'b0;
  logic [3:0]  insn_len_o;
  logic [95:0] insn_bytes_o;

  fetch_aligner i_fetch_aligner (.*);

  always #2.5 clk_i = ~clk_i;

  logic [7:0] mem [256];
  always_comb
    for (int k = 0; k < 4; k++) fetch_data_i[k*8 +: 8] = mem[8'(fetch_addr_o + 32'(k))];

  int n_chk = 0, n_fail = 0;
  int wp, n_exp = 0, k = 0;
  int exp_addr [256], exp_len [256];
  string exp_tag [256];
  int avail = 0, drop = 0;
  logic [31:0] exp_faddr = '0;
  bit prev_stall = 0;
  logic [95:0] prev_bytes;
  logic [31:0] prev_addr;

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    mem[wp[7:0]] = b;
    wp++;
  endtask
  task automatic rec(input int len, input string tag);
    exp_addr[n_exp] = wp; exp_len[n_exp] = len; exp_tag[n_exp] = tag; n_exp++;
  endtask
  task automatic e_short(input logic [7:0] op);
    rec(2, "R2"); put(op); put(op ^ 8'h3C);
  endtask
  task automatic e_one(input logic [7:0] op);
    rec(1, "R2"); put(op);
  endtask
  task automatic e_imm(input logic [7:0] op, input logic [1:0] sel);
    int sz = 1 << sel;
    rec(2 + sz, "R3"); put(op); put({wp[5:0], sel});
    for (int i = 0; i < sz; i++) put(8'(wp * 7));
  endtask
  task automatic e_pfx(input logic [7:0] pfx, input logic [1:0] sel);
    int sz = 1 << sel;
    int p = (pfx >= 8'hFC) ? 2 : 1;
    rec(p + 2 + sz, "R4"); put(pfx);
    if (p == 2) put(8'h99);
    put(8'hD3); put({wp[5:0], sel});
    for (int i = 0; i < sz; i++) put(8'(wp * 5));
  endtask

  // mode 0: ready high; 1: ready toggles; 2: ready 1 in 3, ack withheld 1 in 4
  task automatic run(input int upto, input int mode, output int gaps);
    int cyc = 0;
    bit seen = 0;
    gaps = 0;
    while (k < upto && cyc < 2000) begin
      bit rdy, v, req;
      int cons, len;
      logic [95:0] eb;
      rdy = (mode == 0) ? 1'b1 : (mode == 1) ? bit'(cyc % 2) : (cyc % 3 == 0);
      insn_ready_i = rdy;
      fetch_ack_i  = (mode == 2) ? (cyc % 4 != 1) : 1'b1;
      #1;
      v = insn_valid_o; req = fetch_req_o; len = exp_len[k];
      chk(v == (avail >= len), "R5", 96'(v), 96'(avail >= len));
      if (v) begin
        chk(insn_len_o == 4'(len), exp_tag[k], 96'(insn_len_o), 96'(len));
        chk(insn_addr_o == 32'(exp_addr[k]), "R9", 96'(insn_addr_o), 96'(exp_addr[k]));
        eb = '0;
        for (int i = 0; i < len; i++) eb[i*8 +: 8] = mem[8'(exp_addr[k] + i)];
        chk(insn_bytes_o == eb, "R11", insn_bytes_o, eb);
      end
      if (prev_stall)
        chk(v && insn_bytes_o == prev_bytes && insn_addr_o == prev_addr, "R6", insn_bytes_o, prev_bytes);
      cons = (v && rdy) ? len : 0;
      chk(req == ((16 - avail + cons) >= 4), "R7", 96'(req), 96'((16 - avail + cons) >= 4));
      if (req) chk(fetch_addr_o == exp_faddr, "R7", 96'(fetch_addr_o), 96'(exp_faddr));
      if (seen && !v) gaps++;
      if (v) seen = 1;
      prev_stall = v && !rdy; prev_bytes = insn_bytes_o; prev_addr = insn_addr_o;
      if (req && fetch_ack_i) begin
        avail += 4 - drop; drop = 0; exp_faddr += 4;
      end
      avail -= cons;
      if (cons != 0) k++;
      @(negedge clk_i);
      cyc++;
    end
    chk(k >= upto, "R5", 96'(k), 96'(upto));
  endtask

  task automatic do_redirect(input logic [31:0] target, input int idx);
    redirect_i = 1'b1; redirect_addr_i = target;
    #1;
    chk(insn_valid_o == 1'b0, "R8", 96'(insn_valid_o), 96'(0));
    chk(fetch_req_o == 1'b0, "R8", 96'(fetch_req_o), 96'(0));
    @(negedge clk_i);
    redirect_i = 1'b0;
    #1;
    chk(insn_addr_o == target, "R8", 96'(insn_addr_o), 96'(target));
    chk(fetch_addr_o == {target[31:2], 2'b00}, "R8", 96'(fetch_addr_o), 96'({target[31:2], 2'b00}));
    avail = 0; drop = int'(target[1:0]); exp_faddr = {target[31:2], 2'b00};
    k = idx; prev_stall = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(insn_valid_o == 1'b0, "R1", 96'(insn_valid_o), 96'(0));
    chk(fetch_req_o == 1'b1, "R1", 96'(fetch_req_o), 96'(1));
    chk(fetch_addr_o == 32'd0, "R1", 96'(fetch_addr_o), 96'(0));
    chk(insn_addr_o == 32'd0, "R1", 96'(insn_addr_o), 96'(0));
  endtask

  task automatic t_short;
    int s = n_exp, gaps;
    wp = 'h00;
    for (int i = 0; i < 6; i++) begin
      e_short(8'h00 + 8'(i * 37)); e_one(8'hF0); e_short(8'hBF); e_one(8'hF7);
    end
    do_redirect(32'h0, s);
    run(n_exp, 0, gaps);
    chk(gaps == 0, "R10", 96'(gaps), 96'(0));
  endtask

  task automatic t_imm;
    int s = n_exp, gaps;
    wp = 'h40;
    for (int i = 0; i < 4; i++) begin
      e_imm(8'hC0, 2'(i)); e_imm(8'hEF, 2'(3 - i));
    end
    do_redirect(32'h40, s);
    run(n_exp, 0, gaps);
  endtask

  task automatic t_prefix;
    int s = n_exp, gaps;
    wp = 'h80;
    e_pfx(8'hF8, 2'd3); e_pfx(8'hFF, 2'd3); e_pfx(8'hFB, 2'd0); e_short(8'h12);
    e_pfx(8'hFC, 2'd1); e_pfx(8'hFE, 2'd2); e_one(8'hF3); e_pfx(8'hFC, 2'd3);
    do_redirect(32'h80, s);
    run(n_exp, 0, gaps);
  endtask

  task automatic t_stall;
    int s = n_exp, gaps;
    wp = 'h01;
    for (int i = 0; i < 3; i++) begin
      e_short(8'h21); e_imm(8'hD0, 2'd2); e_one(8'hF5); e_pfx(8'hFD, 2'd3); e_imm(8'hC8, 2'd0);
    end
    do_redirect(32'h01, s);
    run(s + 7, 1, gaps);
    run(n_exp, 2, gaps);
  endtask

  task automatic t_redirect;
    int sa = n_exp, sb, gaps;
    wp = 'h10;
    for (int i = 0; i < 5; i++) begin e_imm(8'hE0, 2'd1); e_short(8'h44); end
    sb = n_exp;
    wp = 'hC6;
    e_short(8'h7A); e_pfx(8'hF9, 2'd2); e_one(8'hF1); e_imm(8'hC3, 2'd3); e_short(8'h05);
    do_redirect(32'h10, sa);
    run(sa + 3, 0, gaps);
    do_redirect(32'hC6, sb);
    run(n_exp, 0, gaps);
    do_redirect(32'h13 + 32'h0, n_exp);
    chk(insn_valid_o == 1'b0, "R8", 96'(insn_valid_o), 96'(0));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_short();
    t_imm();
    t_prefix();
    t_stall();
    t_redirect();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule